// File: doc/BRIEF.md
# Dual-Modulus Swallow Divider

This block sits behind an external two-modulus prescaler and is clocked by that prescaler's output. It keeps two down-counters: a main counter loaded with M and a swallow counter loaded with A. A modulus-select output tells the prescaler which ratio to use. While the swallow counter still has clocks left, the output is low and the prescaler divides by P+1. After that the output is high and the prescaler divides by P until the main counter runs out. Each count cycle of the block therefore lasts M of its own clocks and A·(P+1) + (M−A)·P = M·P + A prescaler input periods. At the last clock of the cycle the block raises a single-clock divided pulse, which goes to a phase comparator.

New ratios come in on a load strobe together with an M and an A value. The block checks each request. A legal request is held as pending and replaces the running ratio only at the next cycle boundary, so a cycle that is under way always completes with the ratio it began with. A request with M below the minimum, or with M not greater than A, is dropped and sets an error flag that stays set until reset.

Top module: `swallow_divider`

## Requirements
- R1: During and after reset the block runs the default ratio (M=10, A=3) from cycle position 0. `modSel` is low, `divPulse` is low and `cfgErr` is low.
- R2: At position k of a cycle (k = 0 .. M−1, counted in clocks since the cycle began), `modSel` is 0 for k < A and 1 for k ≥ A. A value of 0 selects modulus P+1 and a value of 1 selects P.
- R3: `divPulse` is high for exactly one clock per cycle, at position M−1. Pulses are therefore M clocks apart.
- R4: Over any complete cycle, counting P+1 input periods for each clock with `modSel` low and P for each clock with `modSel` high gives a total of M·P + A.
- R5: With A = 0, `modSel` is high from position 0 of the cycle.
- R6: A legal load that arrives part way through a cycle does not change that cycle. It takes effect from position 0 of the next cycle. When several legal loads arrive before a boundary, the last one is used.
- R7: A load sampled on the same clock edge as a cycle boundary is not used at that boundary. It takes effect at the boundary after.
- R8: A load with `loadM` < 8 or `loadM` ≤ `loadA` is rejected. The running and pending ratios stay as they were, and `cfgErr` goes high and stays high until reset.
- R9: The extreme legal ratio M = 1023, A = 127 follows R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output; every register updates on its rising edge |
| rstN | input | 1 | Active-low reset, asynchronous assertion |
| loadStb | input | 1 | Samples `loadM`/`loadA` as a new ratio request |
| loadM | input | 10 | Requested main count M |
| loadA | input | 7 | Requested swallow count A |
| modSel | output | 1 | Modulus select to the prescaler (0: P+1, 1: P) |
| divPulse | output | 1 | One-clock divided pulse at the end of each cycle |
| cfgErr | output | 1 | Sticky flag for a rejected request |

## Verification
The bench targets the edges of the counting cycle. With A = 0, a design that waits one clock before raising `modSel` swallows an extra period and gives M·P + 1. With M = A + 1, a wrong swallow count shows up as a low `modSel` on the pulse clock. Loads are placed in the middle of a cycle and on the exact boundary edge. A design that applies a load at once changes the current cycle, and one that applies a boundary-edge load at that same boundary shortens the cycle by one ratio. Rejected requests are followed by long runs, so a design that partly takes an illegal ratio, or forgets the error, puts the pulse in the wrong place or drops `cfgErr`.

// File: rtl/swc_pkg.sv
package swc_pkg;
  // Strobes from the control module to the datapath for one clock
  typedef struct packed {
    logic wrap;      // cycle boundary: reload the counters
    logic aStep;     // decrement the swallow counter
    logic capture;   // store a legal request as pending
    logic flagErr;   // record a rejected request
  } swcStrobe_t;
endpackage

// File: rtl/swc_control.sv
module swc_control
  import swc_pkg::*;
#(
  parameter int M_W   = 10,
  parameter int A_W   = 7,
  parameter int M_MIN = 8
) (
  input  logic           mDone,
  input  logic           aDone,
  input  logic           loadStb,
  input  logic [M_W-1:0] loadM,
  input  logic [A_W-1:0] loadA,
  output swcStrobe_t     stb
);
  localparam logic [M_W-1:0] MMinV = M_W'(M_MIN);

  logic reqLegal;

  // A is legal over its full width; M needs the floor and M > A
  always_comb begin
    reqLegal = (loadM >= MMinV) && (loadM > M_W'(loadA));
    stb.wrap    = mDone;
    stb.aStep   = !aDone && !mDone;
    stb.capture = loadStb && reqLegal;
    stb.flagErr = loadStb && !reqLegal;
  end
endmodule

// File: rtl/swc_datapath.sv
module swc_datapath
  import swc_pkg::*;
#(
  parameter int M_W   = 10,
  parameter int A_W   = 7,
  parameter int DEF_M = 10,
  parameter int DEF_A = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  swcStrobe_t     stb,
  input  logic [M_W-1:0] loadM,
  input  logic [A_W-1:0] loadA,
  output logic           mDone,
  output logic           aDone,
  output logic           errFlag
);
  localparam logic [M_W-1:0] OneM = M_W'(1);
  localparam logic [A_W-1:0] OneA = A_W'(1);

  logic [M_W-1:0] actM, pendM, mCnt;
  logic [A_W-1:0] actA, pendA, aCnt;
  logic           pendValid;

  // Running counters: mCnt holds the clocks left in the cycle, aCnt the low clocks left
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actM <= M_W'(DEF_M);
      actA <= A_W'(DEF_A);
      mCnt <= M_W'(DEF_M - 1);
      aCnt <= A_W'(DEF_A);
    end else if (stb.wrap) begin
      if (pendValid) begin
        actM <= pendM;
        actA <= pendA;
        mCnt <= pendM - OneM;
        aCnt <= pendA;
      end else begin
        mCnt <= actM - OneM;
        aCnt <= actA;
      end
    end else begin
      mCnt <= mCnt - OneM;
      if (stb.aStep) aCnt <= aCnt - OneA;
    end
  end

  // Pending ratio: set by a legal request, used up at a boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendM     <= '0;
      pendA     <= '0;
      pendValid <= 1'b0;
    end else if (stb.capture) begin
      pendM     <= loadM;
      pendA     <= loadA;
      pendValid <= 1'b1;
    end else if (stb.wrap) begin
      pendValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            errFlag <= 1'b0;
    else if (stb.flagErr) errFlag <= 1'b1;
  end

  assign mDone = (mCnt == '0);
  assign aDone = (aCnt == '0);
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swc_pkg::*;
#(
  parameter int M_W   = 10,
  parameter int A_W   = 7,
  parameter int M_MIN = 8,
  parameter int DEF_M = 10,
  parameter int DEF_A = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           loadStb,
  input  logic [M_W-1:0] loadM,
  input  logic [A_W-1:0] loadA,
  output logic           modSel,
  output logic           divPulse,
  output logic           cfgErr
);
  swcStrobe_t stb;
  logic mDone, aDone, errFlag;

  swc_control #(.M_W(M_W), .A_W(A_W), .M_MIN(M_MIN)) u_ctrl (
    .mDone(mDone), .aDone(aDone), .loadStb(loadStb),
    .loadM(loadM), .loadA(loadA), .stb(stb)
  );

  swc_datapath #(.M_W(M_W), .A_W(A_W), .DEF_M(DEF_M), .DEF_A(DEF_A)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .loadM(loadM), .loadA(loadA),
    .mDone(mDone), .aDone(aDone), .errFlag(errFlag)
  );

  assign modSel   = aDone;
  assign divPulse = mDone;
  assign cfgErr   = errFlag;
endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk #(
  parameter int M_W   = 10,
  parameter int A_W   = 7,
  parameter int M_MIN = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           loadStb,
  input logic [M_W-1:0] loadM,
  input logic [A_W-1:0] loadA,
  input logic           modSel,
  input logic           divPulse,
  input logic           cfgErr
);
  logic badReq;
  assign badReq = loadStb && ((loadM < M_W'(M_MIN)) || (loadM <= M_W'(loadA)));

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN) cfgErr |=> cfgErr); // R8
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rstN) badReq |=> cfgErr); // R8
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN) divPulse |=> !divPulse); // R3
  AST_PULSE_MC_HIGH: assert property (@(posedge clk) disable iff (!rstN) divPulse |-> modSel); // R2
  AST_MC_FALL_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN) $fell(modSel) |-> $past(divPulse)); // R2
endmodule

bind swallow_divider swallow_divider_chk #(.M_W(M_W), .A_W(A_W), .M_MIN(M_MIN)) u_chk (
  .clk(clk), .rstN(rstN), .loadStb(loadStb), .loadM(loadM), .loadA(loadA),
  .modSel(modSel), .divPulse(divPulse), .cfgErr(cfgErr)
);

// File: tb/swallow_divider_tb.sv
module swallow_divider_tb;
  localparam int CLK_PERIOD = 10;
  localparam int P = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadStb = 1'b0;
  logic [9:0] loadM = '0;
  logic [6:0] loadA = '0;
  logic modSel, divPulse, cfgErr;

  int checks = 0, failures = 0;
  int pos = 0, curM = 10, curA = 3, pendM = 0, pendA = 0, sum = 0;
  bit pendV = 0, expErr = 0, done = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  swallow_divider u_dut (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .loadM(loadM), .loadA(loadA),
    .modSel(modSel), .divPulse(divPulse), .cfgErr(cfgErr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic modelAdvance(input bit s, input int m, input int a);
    if (pos == curM - 1) begin
      if (pendV) begin curM = pendM; curA = pendA; pendV = 0; end
      pos = 0;
    end else pos++;
    if (s) begin
      if (m >= 8 && m > a) begin pendM = m; pendA = a; pendV = 1; end
      else expErr = 1;
    end
  endtask

  task automatic compareAll();
    bit eMc, eFv;
    eMc = (pos >= curA);
    eFv = (pos == curM - 1);
    chk(modSel == eMc, {"R2 modSel ", tag}, modSel, eMc);
    chk(divPulse == eFv, {"R3 divPulse ", tag}, divPulse, eFv);
    chk(cfgErr == expErr, {"R8 cfgErr ", tag}, cfgErr, expErr);
    sum += modSel ? P : P + 1;
    if (eFv) begin
      chk(sum == curM * P + curA, {"R4 ratio ", tag}, sum, curM * P + curA);
      sum = 0;
    end
  endtask

  task automatic step(input bit s, input int m, input int a);
    loadStb = s; loadM = 10'(m); loadA = 7'(a);
    @(posedge clk);
    modelAdvance(s, m, a);
    @(negedge clk);
    loadStb = 1'b0;
    compareAll();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(modSel == 1'b0, "R1 modSel in reset", modSel, 0);
    chk(divPulse == 1'b0, "R1 divPulse in reset", divPulse, 0);
    chk(cfgErr == 1'b0, "R1 cfgErr in reset", cfgErr, 0);
    rstN = 1'b1;
    compareAll();
    idle(25);

    tag = "R6 mid-cycle";
    idle(2);
    step(1, 12, 5);
    chk(curM == 10, "R6 current cycle kept", curM, 10);
    step(1, 15, 1);
    step(1, 11, 4);
    idle(40);
    chk(curM == 11 && curA == 4, "R6 last request used", curM, 11);

    tag = "R5 A=0";
    step(1, 8, 0);
    while (!(pos == 0 && curA == 0)) step(0, 0, 0);
    chk(modSel == 1'b1, "R5 modSel high at position 0", modSel, 1);
    idle(20);

    tag = "R7 boundary";
    while (pos != curM - 1) step(0, 0, 0);
    step(1, 9, 2);
    chk(curM == 8 && pos == 0, "R7 old ratio kept at boundary", curM, 8);
    idle(20);
    chk(curM == 9, "R7 ratio applied next boundary", curM, 9);

    tag = "M=A+1";
    step(1, 8, 7);
    idle(30);

    tag = "R8 illegal";
    step(1, 5, 0);
    step(1, 9, 9);
    idle(30);
    chk(cfgErr == 1'b1, "R8 sticky error", cfgErr, 1);
    chk(curM == 8 && curA == 7, "R8 ratio unchanged", curM, 8);

    tag = "R9 extreme";
    step(1, 1023, 127);
    idle(2200);
    chk(curM == 1023, "R9 extreme ratio running", curM, 1023);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule